// File: doc/BRIEF.md
# Oversampling ADC Conversion Sequencer

This block is the digital controller of an oversampling acquisition chain. Software reaches it through a small 8-bit register bus with a 3-bit address. Six addresses hold configuration, and two read-only addresses return the signed 16-bit result. A sampling strobe is made from the system clock by a divider with four selectable ratios. On each strobe taken during a conversion, the 1-bit modulator stream adds +1 or -1 to an accumulator.

A conversion is built from 2^N elementary conversions, and each elementary conversion is made of 2^(3+M) strobed samples. The input is chopped between elementary conversions, so the contribution of the modulator bit changes sign on every odd phase. A single conversion is requested by writing the start bit. A request made while busy is held and runs once the current conversion ends. The continuous bit starts a conversion and then re-triggers one each time a result is stored. The PGA gain, offset and multiplexer bytes, the bias codes and the stage enables are only passed out as control fields.

The sequencer has three states. IDLE waits for a held request. RUN counts samples and phases. LATCH stores the result. The transitions are:
- launch (IDLE to RUN): a request is held and the modulator enable is set.
- abort (RUN to IDLE): the modulator enable is cleared during a conversion.
- finish (RUN to LATCH): the last sample of the last phase has been taken.
- commit (LATCH to IDLE): the result is written and the done pulse is raised.

Top module: `ovs_adc_seq`

## Requirements
- R1: After reset, address 0 reads 0x40, because the oversampling field resets to code 2. Addresses 1 to 7 read 0x00, busy and done are low, and the result is 0.
- R2: Writing 1 to address 0 bit 0 requests exactly one conversion, and that bit always reads 0. A request made while busy is deferred until the current conversion has stored its result. Several requests made during one conversion yield only one further conversion.
- R3: Address 0 bit 1 is the continuous flag. Changing it from 0 to 1 requests a conversion. While it stays 1, each stored result queues the next conversion. After it is cleared, no new conversion begins.
- R4: Address 0 bits 4:3 (N) select 2^N elementary conversions. Bits 7:5 (M) select 2^(3+M) samples per elementary conversion. Both fields are captured at launch, so later writes affect only the next conversion.
- R5: Each sample taken in RUN adds +1 if the modulator bit XOR the phase parity is 1, and adds -1 otherwise. The phase parity is 0 in even phases and 1 in odd phases. The signed sum, saturated to 16 bits, is readable at address 6 (bits 15:8) and address 7 (bits 7:0).
- R6: Address 1 bits 1:0 select a strobe every 2, 4, 8 or 32 clocks, for codes 0 to 3. The strobe never lasts more than one clock.
- R7: Busy is high from launch until commit and reads at address 1 bit 7. At commit, busy falls, the result changes and done is high for exactly one clock, all in the same cycle.
- R8: Address 0 bit 2 is a test bit. It always reads 0 and ignores writes.
- R9: With address 2 bit 0 clear, no conversion is launched and a held request is kept. Clearing the bit during a conversion drops it without a result or a done pulse.
- R10: Address 2 bits 3:0 drive the enable outputs. Address 1 bits 3:2 and 5:4 drive the two bias codes. Addresses 3, 4 and 5 drive the auxiliary bytes [7:0], [15:8] and [23:16]. All of them read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 3 | register address |
| bus_we | input | 1 | write strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr (combinational) |
| mod_bit | input | 1 | modulator bit stream |
| sample_stb | output | 1 | sampling strobe |
| chop_o | output | 1 | current chop phase parity while running |
| busy | output | 1 | conversion in progress |
| done | output | 1 | one-clock pulse when a result is stored |
| enable_o | output | 4 | modulator and PGA stage enables |
| ib_adc_o | output | 2 | modulator bias code |
| ib_pga_o | output | 2 | PGA bias code |
| aux_o | output | 24 | gain, offset and multiplexer bytes |
| result_o | output | 16 | latest stored result |

## Verification
Two functions can fall in the same cycle: a new start request, or a 0-to-1 continuous write, can arrive in the same cycle that LATCH commits a result and re-queues on the continuous flag. Such a request must yield exactly one further conversion. A reference model in the bench tracks the request flag alongside the state. To provoke the collision, a second start is written at every offset that sweeps across the end of a short conversion. Each offset must give exactly two done pulses, and busy, done, result and read data must agree with the model on every clock.

// File: rtl/ovs_adc_pkg.sv
package ovs_adc_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int RES_W  = 16;
    localparam int NELC_W = 2;
    localparam int OSR_W  = 3;
    localparam int DIV_W  = 6;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CLK    = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN     = 3'd2;
    localparam logic [ADDR_W-1:0] A_RES_HI = 3'd6;
    localparam logic [ADDR_W-1:0] A_RES_LO = 3'd7;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_LATCH = 2'd2
    } conv_st_t;

    function automatic logic [DIV_W-1:0] fin_div(input logic [1:0] code);
        unique case (code)
            2'd0:    return DIV_W'(2);
            2'd1:    return DIV_W'(4);
            2'd2:    return DIV_W'(8);
            default: return DIV_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/ovs_stb_div.sv
module ovs_stb_div
    import ovs_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fin,
    output logic       stb
);
    localparam int CNT_W = DIV_W - 1;

    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim = fin_div(fin) - DIV_W'(1);
        stb = ({1'b0, cnt} >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (stb) cnt <= '0;
        else          cnt <= cnt + CNT_W'(1);
    end

    // R6
    stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);
endmodule

// File: rtl/ovs_regs.sv
module ovs_regs
    import ovs_adc_pkg::*;
#(
    parameter int AUX_N = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   we,
    input  logic [REG_W-1:0]       wdata,
    input  logic                   busy,
    input  logic [RES_W-1:0]       result,
    output logic [REG_W-1:0]       rdata,
    output logic                   start_req,
    output logic                   cont,
    output logic [NELC_W-1:0]      nelc,
    output logic [OSR_W-1:0]       osr,
    output logic [1:0]             fin,
    output logic [1:0]             ib_adc,
    output logic [1:0]             ib_pga,
    output logic [3:0]             enable,
    output logic [AUX_N*REG_W-1:0] aux
);
    localparam logic [OSR_W-1:0] OSR_RST = OSR_W'(2);

    logic wr_ctrl, wr_clk, wr_en;
    logic [AUX_N*REG_W-1:0] aux_q;

    assign wr_ctrl   = we && (addr == A_CTRL);
    assign wr_clk    = we && (addr == A_CLK);
    assign wr_en     = we && (addr == A_EN);
    assign start_req = wr_ctrl && (wdata[0] || (wdata[1] && !cont));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont <= 1'b0;
            nelc <= '0;
            osr  <= OSR_RST;
        end else if (wr_ctrl) begin
            cont <= wdata[1];
            nelc <= wdata[4:3];
            osr  <= wdata[7:5];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin    <= '0;
            ib_adc <= '0;
            ib_pga <= '0;
        end else if (wr_clk) begin
            fin    <= wdata[1:0];
            ib_adc <= wdata[3:2];
            ib_pga <= wdata[5:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     enable <= '0;
        else if (wr_en) enable <= wdata[3:0];
    end

    for (genvar g = 0; g < AUX_N; g++) begin : g_aux
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                aux_q[g*REG_W +: REG_W] <= '0;
            else if (we && (addr == ADDR_W'(3 + g)))
                aux_q[g*REG_W +: REG_W] <= wdata;
        end
    end
    assign aux = aux_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:   rdata = {osr, nelc, 1'b0, cont, 1'b0};
            A_CLK:    rdata = {busy, 1'b0, ib_pga, ib_adc, fin};
            A_EN:     rdata = {4'b0, enable};
            A_RES_HI: rdata = result[RES_W-1 -: REG_W];
            A_RES_LO: rdata = result[REG_W-1:0];
            default:  rdata = aux_q[(int'(addr) - 3)*REG_W +: REG_W];
        endcase
    end
endmodule

// File: rtl/ovs_conv_fsm.sv
module ovs_conv_fsm
    import ovs_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cont,
    input  logic              en0,
    input  logic [NELC_W-1:0] nelc,
    input  logic [OSR_W-1:0]  osr,
    input  logic              stb,
    input  logic              mod_bit,
    output logic              busy,
    output logic              done,
    output logic              chop,
    output logic [RES_W-1:0]  result
);
    localparam int PH_W   = (1 << NELC_W) - 1;
    localparam int SCNT_W = 3 + (1 << OSR_W) - 1;
    localparam int ACC_W  = PH_W + SCNT_W + 2;

    conv_st_t st, nxt;
    logic              pend, launch, last_smp, last_ph;
    logic [NELC_W-1:0] nelc_s;
    logic [OSR_W-1:0]  osr_s;
    logic [SCNT_W-1:0] scnt, s_last;
    logic [PH_W-1:0]   ph, p_last;
    logic [SCNT_W:0]   s_one, s_tmp;
    logic [PH_W:0]     p_one, p_tmp;
    logic signed [ACC_W-1:0] acc;
    logic [RES_W-1:0]  res_val;

    always_comb begin
        s_one    = (SCNT_W+1)'(1);
        p_one    = (PH_W+1)'(1);
        s_tmp    = (s_one << (3 + int'(osr_s))) - s_one;
        p_tmp    = (p_one << nelc_s) - p_one;
        s_last   = s_tmp[SCNT_W-1:0];
        p_last   = p_tmp[PH_W-1:0];
        last_smp = (scnt == s_last);
        last_ph  = (ph == p_last);
    end

    if (ACC_W > RES_W) begin : g_sat
        localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (RES_W-1)) - 1);
        localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);
        always_comb begin
            if (acc > HI)      res_val = RES_W'(HI);
            else if (acc < LO) res_val = RES_W'(LO);
            else               res_val = RES_W'(acc);
        end
    end else begin : g_ext
        assign res_val = RES_W'(acc);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (pend && en0) nxt = S_RUN;
            S_RUN: begin
                if (!en0)                              nxt = S_IDLE;
                else if (stb && last_smp && last_ph)   nxt = S_LATCH;
            end
            S_LATCH: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign launch = (st == S_IDLE) && (nxt == S_RUN);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            acc    <= '0;
            scnt   <= '0;
            ph     <= '0;
            nelc_s <= '0;
            osr_s  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            pend <= (pend && !launch) || start_req || ((st == S_LATCH) && cont);
            done <= (st == S_LATCH);
            if (launch) begin
                acc    <= '0;
                scnt   <= '0;
                ph     <= '0;
                nelc_s <= nelc;
                osr_s  <= osr;
            end else if ((st == S_RUN) && en0 && stb) begin
                acc <= acc + ((mod_bit ^ ph[0]) ? ACC_W'(1) : {ACC_W{1'b1}});
                if (last_smp) begin
                    scnt <= '0;
                    if (!last_ph) ph <= ph + PH_W'(1);
                end else begin
                    scnt <= scnt + SCNT_W'(1);
                end
            end
            if (st == S_LATCH) result <= res_val;
        end
    end

    // outputs
    always_comb begin
        busy = (st != S_IDLE);
        chop = (st == S_RUN) && ph[0];
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    launch_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en0));
    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
endmodule

// File: rtl/ovs_adc_seq.sv
module ovs_adc_seq
    import ovs_adc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        mod_bit,
    output logic        sample_stb,
    output logic        chop_o,
    output logic        busy,
    output logic        done,
    output logic [3:0]  enable_o,
    output logic [1:0]  ib_adc_o,
    output logic [1:0]  ib_pga_o,
    output logic [23:0] aux_o,
    output logic [15:0] result_o
);
    logic              start_req, cont;
    logic [NELC_W-1:0] nelc;
    logic [OSR_W-1:0]  osr;
    logic [1:0]        fin;

    ovs_regs #(.AUX_N(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .busy(busy), .result(result_o), .rdata(bus_rdata), .start_req(start_req),
        .cont(cont), .nelc(nelc), .osr(osr), .fin(fin), .ib_adc(ib_adc_o),
        .ib_pga(ib_pga_o), .enable(enable_o), .aux(aux_o)
    );

    ovs_stb_div u_div (
        .clk(clk), .rst_n(rst_n), .fin(fin), .stb(sample_stb)
    );

    ovs_conv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cont(cont),
        .en0(enable_o[0]), .nelc(nelc), .osr(osr), .stb(sample_stb),
        .mod_bit(mod_bit), .busy(busy), .done(done), .chop(chop_o),
        .result(result_o)
    );
endmodule

// File: tb/ovs_adc_seq_test.sv
module ovs_adc_seq_test;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic [2:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        mod_bit = 0;
    logic        sample_stb, chop_o, busy, done;
    logic [3:0]  enable_o;
    logic [1:0]  ib_adc_o, ib_pga_o;
    logic [23:0] aux_o;
    logic [15:0] result_o;

    ovs_adc_seq uut (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, n_done = 0;
    int mod_mode = 0;   // 0 constant, 1 follow inverted chop
    logic mod_const = 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_reg [0:5];
    bit   m_pend, m_done, m_on;
    int   m_st, m_cnt, m_acc, m_sc, m_ph, m_nelc, m_osr;
    logic [15:0] m_res;

    function automatic int m_div();
        case (m_reg[1][1:0])
            2'd0: return 2;
            2'd1: return 4;
            2'd2: return 8;
            default: return 32;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_reg[0];
            3'd1: return {m_st != 0, 1'b0, m_reg[1][5:0]};
            3'd6: return m_res[15:8];
            3'd7: return m_res[7:0];
            default: return m_reg[a];
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
            m_reg[0] = 8'h40;
            m_pend = 0; m_done = 0; m_st = 0; m_cnt = 0; m_acc = 0;
            m_sc = 0; m_ph = 0; m_res = 0; m_nelc = 1; m_osr = 8;
        end else begin
            automatic bit stb  = (m_cnt >= m_div() - 1);
            automatic bit en0  = m_reg[2][0];
            automatic bit cont = m_reg[0][1];
            automatic bit set  = 0;
            m_cnt  = stb ? 0 : m_cnt + 1;
            m_done = 0;
            case (m_st)
                0: if (m_pend && en0) begin
                    m_st = 1; m_pend = 0; m_acc = 0; m_sc = 0; m_ph = 0;
                    m_nelc = 1 << m_reg[0][4:3];
                    m_osr  = 8 << m_reg[0][7:5];
                end
                1: if (!en0) m_st = 0;
                   else if (stb) begin
                       m_acc += ((mod_bit ^ (m_ph % 2)) != 0) ? 1 : -1;
                       m_sc++;
                       if (m_sc == m_osr) begin
                           m_sc = 0; m_ph++;
                           if (m_ph == m_nelc) m_st = 2;
                       end
                   end
                default: begin
                    m_res  = (m_acc > 32767) ? 16'h7FFF :
                             (m_acc < -32768) ? 16'h8000 : 16'(m_acc);
                    m_done = 1; m_st = 0;
                    if (cont) set = 1;
                end
            endcase
            if (bus_we) begin
                case (bus_addr)
                    3'd0: begin
                        if (bus_wdata[0] || (bus_wdata[1] && !cont)) set = 1;
                        m_reg[0] = bus_wdata & 8'hFA;
                    end
                    3'd1: m_reg[1] = bus_wdata & 8'h3F;
                    3'd2: m_reg[2] = bus_wdata & 8'h0F;
                    3'd3, 3'd4, 3'd5: m_reg[bus_addr] = bus_wdata;
                    default: ;
                endcase
            end
            if (set) m_pend = 1;
            #(CLK_P/4);
            if (m_on) begin
                chk(busy == (m_st != 0), "R7 busy", busy, m_st != 0);
                chk(done == m_done, "R7 done", done, m_done);
                chk(result_o == m_res, "R5 result", result_o, m_res);
                chk(sample_stb == (m_cnt >= m_div() - 1), "R6 strobe", sample_stb, m_cnt >= m_div() - 1);
                chk(chop_o == (m_st == 1 && (m_ph % 2) == 1), "R5 chop", chop_o, m_st == 1 && (m_ph % 2) == 1);
                chk(bus_rdata == m_read(bus_addr), "R8 readback", bus_rdata, m_read(bus_addr));
                chk(enable_o == m_reg[2][3:0] && aux_o == {m_reg[5], m_reg[4], m_reg[3]},
                    "R10 fields", {enable_o, aux_o}, {m_reg[2][3:0], m_reg[5], m_reg[4], m_reg[3]});
            end
            if (done) n_done++;
        end
    end

    always @(negedge clk)
        mod_bit <= (mod_mode == 1) ? ~chop_o : mod_const;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_done();
        automatic int base = n_done;
        automatic int t = 0;
        while (n_done == base && t < 40000) begin @(negedge clk); t++; end
        if (n_done == base) chk(0, "R7 done timeout", 0, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base;
        idle(3);
        rst_n = 1;
        m_on = 1;
        // R1 reset state
        rd(0, d); chk(d == 8'h40, "R1 ctrl reset", d, 8'h40);
        rd(1, d); chk(d == 8'h00, "R1 clk reset", d, 0);
        rd(6, d); chk(d == 8'h00, "R1 result reset", d, 0);
        chk(busy == 0 && done == 0, "R1 idle", busy, 0);

        // R5 basic sums
        wr(2, 8'h01);
        mod_mode = 0; mod_const = 1;
        wr(0, 8'h01); wait_done(); idle(1);
        chk(result_o == 16'd8, "R5 plus eight", result_o, 8);
        rd(0, d); chk(d[0] == 0, "R2 start reads zero", d, 0);
        mod_const = 0;
        wr(0, 8'h01); wait_done(); idle(1);
        chk(result_o == 16'hFFF8, "R5 minus eight", result_o, 16'hFFF8);
        rd(6, d); chk(d == 8'hFF, "R5 high byte", d, 8'hFF);
        rd(7, d); chk(d == 8'hF8, "R5 low byte", d, 8'hF8);

        // R5 chopping
        mod_mode = 1;
        wr(0, 8'h09); wait_done(); idle(1);
        chk(result_o == 16'd16, "R5 chop follow", result_o, 16);
        mod_mode = 0; mod_const = 1;
        wr(0, 8'h09); wait_done(); idle(1);
        chk(result_o == 16'd0, "R5 chop cancel", result_o, 0);

        // R4 counts with slower strobe
        wr(1, 8'h01);
        mod_mode = 1;
        wr(0, 8'h31); wait_done(); idle(1);
        chk(result_o == 16'd64, "R4 four by sixteen", result_o, 64);
        mod_mode = 0; mod_const = 1;
        wr(0, 8'h01); idle(4); wr(0, 8'hE0); wait_done(); idle(1);
        chk(result_o == 16'd8, "R4 snapshot", result_o, 8);

        // R2 queued start
        base = n_done;
        wr(0, 8'h01); idle(3); wr(0, 8'h01); wr(0, 8'h01);
        idle(200);
        chk(n_done - base == 2, "R2 queued once", n_done - base, 2);
        chk(busy == 0, "R2 idle after", busy, 0);

        // R3 continuous
        base = n_done;
        wr(0, 8'h02); idle(200);
        chk(n_done - base >= 4, "R3 retrigger", n_done - base, 4);
        wr(0, 8'h00); idle(100);
        base = n_done; idle(100);
        chk(n_done == base && busy == 0, "R3 stop", n_done - base, 0);

        // R8 test bit
        wr(0, 8'h04); rd(0, d);
        chk(d == 8'h00, "R8 test bit", d, 0);

        // R9 enable gating
        base = n_done;
        wr(0, 8'hE1); idle(20); wr(2, 8'h00); idle(1);
        chk(busy == 0, "R9 abort", busy, 0);
        idle(50);
        chk(n_done == base, "R9 no done", n_done - base, 0);
        wr(0, 8'h01); idle(30);
        chk(busy == 0, "R9 held", busy, 0);
        wr(2, 8'h01); idle(2);
        chk(busy == 1, "R9 release", busy, 1);
        wait_done(); idle(1);
        chk(result_o == 16'd8, "R9 result", result_o, 8);

        // R10 pass-through fields
        wr(3, 8'hA5); wr(5, 8'h5A); wr(2, 8'h0F); wr(1, 8'h3D);
        chk(aux_o == 24'h5A00A5, "R10 aux", aux_o, 24'h5A00A5);
        chk(ib_adc_o == 2'b11 && ib_pga_o == 2'b11, "R10 bias", {ib_adc_o, ib_pga_o}, 4'hF);
        chk(enable_o == 4'hF, "R10 enable", enable_o, 4'hF);
        rd(1, d); chk(d == 8'h3D, "R10 bias readback", d, 8'h3D);

        // R6 slowest strobe period
        wr(1, 8'h03);
        begin
            int t0, t1, t;
            t = 0;
            while (!sample_stb) begin @(negedge clk); t++; end
            t0 = t; @(negedge clk); t++;
            while (!sample_stb) begin @(negedge clk); t++; end
            t1 = t;
            chk(t1 - t0 == 32, "R6 period", t1 - t0, 32);
        end

        // start request colliding with commit
        wr(1, 8'h00);
        for (int k = 8; k <= 26; k++) begin
            base = n_done;
            wr(0, 8'h01); idle(k); wr(0, 8'h01); idle(60);
            chk(n_done - base == 2, "R2 collision sweep", n_done - base, 2);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule